// File: doc/BRIEF.md
# Flash Supervisory Command Controller

This block is the command engine that stands between a processor and a flash array organised in 128-byte blocks. The caller presents a function code and a parameter set in a single cycle: two key bytes, the stack pointer at issue time, a block or table number, an SRAM start offset and an SRAM page. The caller also marks whether the request comes from an external programmer or from code running on the chip. The engine checks the keys, the function code, the range of the identifier and the protection level of the target block. It then streams a block copy, a block clear, a whole-array clear or an 8-byte table read through plain memory ports, and finishes with a one-cycle completion pulse and a status code.

Protection is held as two bits per block. It is loaded one byte at a time, and each byte covers four consecutive blocks. Write permission depends on whether the caller is external or internal. A whole-array clear requested by internal code does not touch the array. Instead it raises a halt line that stays up until reset.

Top module: `flash_sup_ctrl`

## Requirements
- R1: A command runs only if key A equals 3Ah and key B equals the issue-time stack pointer plus 3, taken modulo 256. Otherwise it finishes with status 1 and writes no flash.
- R2: Function codes 02h (block copy), 03h (block clear), 05h (array clear) and 06h (table read) are accepted. Any other code with valid keys finishes with status 2 and writes no flash.
- R3: A block copy writes flash byte i of block B (flash address B*128+i) from SRAM address {page, (start+i) mod 256}, for i = 0..127. It ends with status 0, and the result keys echo the keys that were issued.
- R4: A block clear writes 00h to all 128 bytes of the selected block and ends with status 0.
- R5: A block number of NBLK or more on a copy or clear, or a table number above 3 on a table read, ends with status 3 and no flash write or table strobe.
- R6: Protection byte k sets the levels of blocks 4k to 4k+3. Block 4k+j takes bits 2j+1:2j of that byte.
- R7: Level 00 allows all writes and 01 allows all writes. Level 10 refuses external writes. Level 11 refuses all writes. A refused copy or clear ends with status 4, result key A 01h and result key B 00h, and leaves flash unchanged.
- R8: An external array clear writes 00h to every flash byte, resets every protection level to 00 and ends with status 0.
- R9: An internal array clear ends with status 5, writes no flash and raises halt. Halt stays high until reset, and no later command is accepted while it is high.
- R10: A table read of table t emits table bytes t*8+0 to t*8+7 in order, one per cycle with rd_valid high, and ends with status 0.
- R11: busy is high from the cycle after acceptance through the last access. done is a one-cycle pulse that follows, and busy is low while done is high.
- R12: After reset, busy, done and halt are low and status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request, one cycle |
| cmd_func | input | 8 | Function code |
| cmd_key1 | input | 8 | Key A |
| cmd_key2 | input | 8 | Key B |
| cmd_sp | input | 8 | Caller stack pointer at issue |
| cmd_blkid | input | 8 | Block number or table number |
| cmd_ptr | input | 8 | SRAM start offset within the page |
| cmd_page | input | PAGE_W | SRAM page |
| cmd_ext | input | 1 | 1 = external programmer, 0 = internal code |
| prot_we | input | 1 | Protection byte load strobe |
| prot_byte | input | BI_W | Protection byte index |
| prot_wdata | input | 8 | Packed protection levels |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completion pulse |
| status | output | 3 | Result code |
| res_key1 | output | 8 | Result key A |
| res_key2 | output | 8 | Result key B |
| halt | output | 1 | Sticky halt request |
| sram_addr | output | PAGE_W+8 | SRAM read address |
| sram_rdata | input | 8 | SRAM read data, same cycle |
| fl_we | output | 1 | Flash byte write strobe |
| fl_addr | output | BLK_W+7 | Flash byte address |
| fl_wdata | output | 8 | Flash write data |
| tbl_addr | output | 5 | Table byte address |
| tbl_rdata | input | 8 | Table byte, same cycle |
| rd_valid | output | 1 | Table byte strobe |
| rd_data | output | 8 | Table byte out |

## Verification
The bench builds the block with NBLK = 8 and PAGE_W = 2. With eight blocks there are two protection bytes, so the bench can check the packing across a byte boundary, including a level placed in the second byte. The bench also clears the whole array in 1024 cycles. With four pages, the copy can come from a page other than zero, and a start offset near the top of a page shows the offset wrapping inside that page.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
   typedef enum logic [2:0] {
      ST_OK    = 3'd0,
      ST_KEY   = 3'd1,
      ST_FUNC  = 3'd2,
      ST_RANGE = 3'd3,
      ST_WPROT = 3'd4,
      ST_HALT  = 3'd5
   } fsc_stat_e;

   typedef enum logic [1:0] {
      OP_COPY  = 2'd0,
      OP_CLR   = 2'd1,
      OP_CLALL = 2'd2,
      OP_TBL   = 2'd3
   } fsc_op_e;

   localparam logic [7:0] FN_COPY  = 8'h02;
   localparam logic [7:0] FN_CLR   = 8'h03;
   localparam logic [7:0] FN_CLALL = 8'h05;
   localparam logic [7:0] FN_TBL   = 8'h06;
   localparam logic [7:0] KEY_A    = 8'h3A;
   localparam logic [7:0] KEY_OFS  = 8'h03;
   localparam logic [7:0] FAIL_KA  = 8'h01;
   localparam int         NTBL     = 4;
   localparam int         TBL_LEN  = 8;
endpackage

// File: rtl/fsc_gate.sv
module fsc_gate
   import fsc_pkg::*;
#(
   parameter int NBLK = 16
) (
   input  logic [7:0] func,
   input  logic [7:0] key1,
   input  logic [7:0] key2,
   input  logic [7:0] sp,
   input  logic [7:0] id,
   input  logic       ext,
   input  logic       wr_ok,
   output fsc_stat_e  verdict,
   output fsc_op_e    op
);
   logic       known;
   logic       key_ok;
   logic [7:0] want_b;

   assign want_b = sp + KEY_OFS;
   assign key_ok = (key1 == KEY_A) && (key2 == want_b);

   always_comb begin
      known = 1'b1;
      op    = OP_COPY;
      case (func)
         FN_COPY:  op = OP_COPY;
         FN_CLR:   op = OP_CLR;
         FN_CLALL: op = OP_CLALL;
         FN_TBL:   op = OP_TBL;
         default:  known = 1'b0;
      endcase
   end

   always_comb begin
      verdict = ST_OK;
      if (!key_ok) begin
         verdict = ST_KEY;
      end else if (!known) begin
         verdict = ST_FUNC;
      end else begin
         case (op)
            OP_COPY, OP_CLR: begin
               if (int'(id) >= NBLK)  verdict = ST_RANGE;
               else if (!wr_ok)       verdict = ST_WPROT;
            end
            OP_CLALL: if (!ext)       verdict = ST_HALT;
            OP_TBL:   if (int'(id) >= NTBL) verdict = ST_RANGE;
            default:  verdict = ST_OK;
         endcase
      end
   end

   // R1: a mismatched key never passes the gate
   always_comb begin
      if (key1 != KEY_A)
         a_keya_r1: assert (verdict == ST_KEY);
   end
endmodule

// File: rtl/fsc_prot.sv
module fsc_prot #(
   parameter int NBLK  = 16,
   parameter int BLK_W = $clog2(NBLK),
   parameter int BI_W  = (NBLK / 4 > 1) ? $clog2(NBLK / 4) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [BI_W-1:0]  ld_byte,
   input  logic [7:0]       ld_data,
   input  logic             clr_all,
   input  logic [BLK_W-1:0] q_blk,
   input  logic             q_ext,
   output logic             wr_ok
);
   logic [1:0] lvl [NBLK];
   logic [1:0] mode;

   for (genvar g = 0; g < NBLK; g++) begin : g_lvl
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                lvl[g] <= 2'b00;
         else if (clr_all)                          lvl[g] <= 2'b00;
         else if (ld && int'(ld_byte) == g / 4)     lvl[g] <= ld_data[2*(g%4) +: 2];
      end

      p_clr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
         $past(clr_all) |-> (lvl[g] == 2'b00));
   end

   assign mode  = lvl[q_blk];
   // external writers need level 00/01; internal writers are refused only at 11
   assign wr_ok = q_ext ? !mode[1] : (mode != 2'b11);
endmodule

// File: rtl/fsc_walk.sv
module fsc_walk #(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   input  logic [CNT_W-1:0] last,
   output logic [CNT_W-1:0] idx,
   output logic             at_end
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     idx <= '0;
      else if (start) idx <= '0;
      else if (run)   idx <= idx + 1'b1;
   end

   assign at_end = (idx == last);

   p_idx_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (idx <= last));
endmodule

// File: rtl/flash_sup_ctrl.sv
module flash_sup_ctrl
   import fsc_pkg::*;
#(
   parameter int NBLK   = 16,
   parameter int PAGE_W = 3,
   localparam int BLK_W = $clog2(NBLK),
   localparam int CNT_W = BLK_W + 7,
   localparam int BI_W  = (NBLK / 4 > 1) ? $clog2(NBLK / 4) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [7:0]        cmd_func,
   input  logic [7:0]        cmd_key1,
   input  logic [7:0]        cmd_key2,
   input  logic [7:0]        cmd_sp,
   input  logic [7:0]        cmd_blkid,
   input  logic [7:0]        cmd_ptr,
   input  logic [PAGE_W-1:0] cmd_page,
   input  logic              cmd_ext,
   input  logic              prot_we,
   input  logic [BI_W-1:0]   prot_byte,
   input  logic [7:0]        prot_wdata,
   output logic              busy,
   output logic              done,
   output logic [2:0]        status,
   output logic [7:0]        res_key1,
   output logic [7:0]        res_key2,
   output logic              halt,
   output logic [PAGE_W+7:0] sram_addr,
   input  logic [7:0]        sram_rdata,
   output logic              fl_we,
   output logic [CNT_W-1:0]  fl_addr,
   output logic [7:0]        fl_wdata,
   output logic [4:0]        tbl_addr,
   input  logic [7:0]        tbl_rdata,
   output logic              rd_valid,
   output logic [7:0]        rd_data
);
   if (NBLK < 4 || (NBLK & (NBLK - 1)) != 0) begin : g_bad_nblk
      $error("NBLK must be a power of two of at least 4");
   end
   if (PAGE_W < 1 || PAGE_W > 8) begin : g_bad_page
      $error("PAGE_W must lie in 1..8");
   end

   typedef enum logic [1:0] {S_IDLE, S_CHK, S_RUN, S_FIN} state_e;

   state_e            state;
   fsc_op_e           op;
   fsc_stat_e         verdict;
   fsc_stat_e         stat_q;
   logic [7:0]        func_q, k1_q, k2_q, sp_q, id_q, ptr_q;
   logic [PAGE_W-1:0] page_q;
   logic              ext_q, halt_q, wr_ok, at_end, clr_prot;
   logic [CNT_W-1:0]  idx, last;

   fsc_gate #(.NBLK(NBLK)) u_gate (
      .func(func_q), .key1(k1_q), .key2(k2_q), .sp(sp_q), .id(id_q),
      .ext(ext_q), .wr_ok(wr_ok), .verdict(verdict), .op(op)
   );

   fsc_prot #(.NBLK(NBLK), .BLK_W(BLK_W), .BI_W(BI_W)) u_prot (
      .clk(clk), .rst_n(rst_n), .ld(prot_we), .ld_byte(prot_byte),
      .ld_data(prot_wdata), .clr_all(clr_prot), .q_blk(id_q[BLK_W-1:0]),
      .q_ext(ext_q), .wr_ok(wr_ok)
   );

   always_comb begin
      case (op)
         OP_CLALL: last = CNT_W'(NBLK * 128 - 1);
         OP_TBL:   last = CNT_W'(TBL_LEN - 1);
         default:  last = CNT_W'(127);
      endcase
   end

   fsc_walk #(.CNT_W(CNT_W)) u_walk (
      .clk(clk), .rst_n(rst_n), .start(state == S_CHK), .run(state == S_RUN),
      .last(last), .idx(idx), .at_end(at_end)
   );

   assign clr_prot = (state == S_RUN) && (op == OP_CLALL) && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         stat_q   <= ST_OK;
         halt_q   <= 1'b0;
         func_q   <= '0; k1_q <= '0; k2_q <= '0; sp_q <= '0;
         id_q     <= '0; ptr_q <= '0; page_q <= '0; ext_q <= 1'b0;
         res_key1 <= '0; res_key2 <= '0;
      end else begin
         case (state)
            S_IDLE: if (cmd_valid && !halt_q) begin
               func_q <= cmd_func; k1_q <= cmd_key1; k2_q <= cmd_key2;
               sp_q   <= cmd_sp;   id_q <= cmd_blkid; ptr_q <= cmd_ptr;
               page_q <= cmd_page; ext_q <= cmd_ext;
               state  <= S_CHK;
            end
            S_CHK: begin
               stat_q <= verdict;
               if (verdict == ST_OK) begin
                  res_key1 <= k1_q;
                  res_key2 <= k2_q;
                  state    <= S_RUN;
               end else begin
                  state <= S_FIN;
                  if (verdict == ST_WPROT) begin
                     res_key1 <= FAIL_KA;
                     res_key2 <= 8'h00;
                  end
                  if (verdict == ST_HALT) halt_q <= 1'b1;
               end
            end
            S_RUN:   if (at_end) state <= S_FIN;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign busy      = (state == S_CHK) || (state == S_RUN);
   assign done      = (state == S_FIN);
   assign status    = stat_q;
   assign halt      = halt_q;
   assign fl_we     = (state == S_RUN) && (op != OP_TBL);
   assign fl_addr   = (op == OP_CLALL) ? idx : {id_q[BLK_W-1:0], idx[6:0]};
   assign fl_wdata  = (op == OP_COPY) ? sram_rdata : 8'h00;
   assign sram_addr = {page_q, 8'(ptr_q + {1'b0, idx[6:0]})};
   assign tbl_addr  = {id_q[1:0], idx[2:0]};
   assign rd_valid  = (state == S_RUN) && (op == OP_TBL);
   assign rd_data   = tbl_rdata;

   p_we_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_we || rd_valid) |-> busy);
   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(halt) |-> halt);
   p_reject_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_CHK && verdict != ST_OK) |=> (!fl_we && !rd_valid));
   p_tbl_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !fl_we);
endmodule

// File: tb/tb_flash_sup_ctrl.sv
module tb_flash_sup_ctrl;
   localparam int CLK_PER = 10;
   localparam int NBLK    = 8;
   localparam int PAGE_W  = 2;
   localparam int FSZ     = NBLK * 128;
   localparam int SSZ     = (1 << PAGE_W) * 256;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_valid = 1'b0, cmd_ext = 1'b0;
   logic [7:0] cmd_func = '0, cmd_key1 = '0, cmd_key2 = '0, cmd_sp = '0;
   logic [7:0] cmd_blkid = '0, cmd_ptr = '0;
   logic [PAGE_W-1:0] cmd_page = '0;
   logic prot_we = 1'b0;
   logic [0:0] prot_byte = '0;
   logic [7:0] prot_wdata = '0;
   logic busy, done, halt, fl_we, rd_valid;
   logic [2:0] status;
   logic [7:0] res_key1, res_key2, sram_rdata, fl_wdata, tbl_rdata, rd_data;
   logic [PAGE_W+7:0] sram_addr;
   logic [9:0] fl_addr;
   logic [4:0] tbl_addr;

   logic [7:0] sram [SSZ];
   logic [7:0] flash [FSZ];
   logic [7:0] shadow [FSZ];
   logic [7:0] tbl [32];
   logic [7:0] rbuf [64];
   int rcnt = 0;
   int ntot = 0, nbad = 0;

   always #(CLK_PER/2) clk = ~clk;

   flash_sup_ctrl #(.NBLK(NBLK), .PAGE_W(PAGE_W)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_func(cmd_func),
      .cmd_key1(cmd_key1), .cmd_key2(cmd_key2), .cmd_sp(cmd_sp),
      .cmd_blkid(cmd_blkid), .cmd_ptr(cmd_ptr), .cmd_page(cmd_page),
      .cmd_ext(cmd_ext), .prot_we(prot_we), .prot_byte(prot_byte),
      .prot_wdata(prot_wdata), .busy(busy), .done(done), .status(status),
      .res_key1(res_key1), .res_key2(res_key2), .halt(halt),
      .sram_addr(sram_addr), .sram_rdata(sram_rdata), .fl_we(fl_we),
      .fl_addr(fl_addr), .fl_wdata(fl_wdata), .tbl_addr(tbl_addr),
      .tbl_rdata(tbl_rdata), .rd_valid(rd_valid), .rd_data(rd_data)
   );

   assign sram_rdata = sram[sram_addr];
   assign tbl_rdata  = tbl[tbl_addr];

   always @(posedge clk) begin
      if (fl_we) flash[fl_addr] <= fl_wdata;
      if (rd_valid) begin
         rbuf[rcnt % 64] <= rd_data;
         rcnt <= rcnt + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      ntot++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cmp_flash(input string tag);
      int nmis = 0;
      int first = -1;
      for (int i = 0; i < FSZ; i++)
         if (flash[i] !== shadow[i]) begin
            nmis++;
            if (first < 0) first = i;
         end
      chk(nmis == 0, tag, (first < 0) ? 0 : flash[first],
          (first < 0) ? 0 : shadow[first]);
   endtask

   task automatic issue(input logic [7:0] fn, input logic [7:0] ka, input logic [7:0] kb,
                        input logic [7:0] sp, input logic [7:0] id, input logic [7:0] ptr,
                        input int page, input bit ext, output bit got, output bit busy_seen);
      int n = 0;
      @(negedge clk);
      cmd_func = fn; cmd_key1 = ka; cmd_key2 = kb; cmd_sp = sp;
      cmd_blkid = id; cmd_ptr = ptr; cmd_page = PAGE_W'(page); cmd_ext = ext;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      busy_seen = busy;
      while (!done && n < 3000) begin
         @(negedge clk);
         n++;
      end
      got = done;
   endtask

   task automatic t_reset;
      chk(busy == 1'b0 && done == 1'b0 && halt == 1'b0, "R12 reset outputs",
          {busy, done, halt}, 0);
      chk(status == 3'd0, "R12 reset status", status, 0);
   endtask

   task automatic t_copy;
      bit got, bs;
      issue(8'h02, 8'h3A, 8'h43, 8'h40, 8'd3, 8'h90, 2, 1'b1, got, bs);
      for (int i = 0; i < 128; i++) shadow[3*128+i] = sram[2*256 + ((8'h90 + i) % 256)];
      chk(got && status == 3'd0, "R3 copy status", status, 0);
      chk(bs == 1'b1 && busy == 1'b0, "R11 busy window", {bs, busy}, 2);
      chk(res_key1 == 8'h3A && res_key2 == 8'h43, "R3 keys echoed", {res_key1, res_key2}, 16'h3A43);
      cmp_flash("R3 copy data with page wrap");
      @(negedge clk);
      chk(done == 1'b0, "R11 done single cycle", done, 0);
   endtask

   task automatic t_clear;
      bit got, bs;
      // stack pointer FEh: key B wraps to 01h
      issue(8'h03, 8'h3A, 8'h01, 8'hFE, 8'd3, 8'h00, 0, 1'b0, got, bs);
      for (int i = 0; i < 128; i++) shadow[3*128+i] = 8'h00;
      chk(got && status == 3'd0, "R4 clear status (R1 wrap key)", status, 0);
      cmp_flash("R4 clear data");
   endtask

   task automatic t_badkey;
      bit got, bs;
      issue(8'h02, 8'h3B, 8'h43, 8'h40, 8'd3, 8'h00, 0, 1'b1, got, bs);
      chk(got && status == 3'd1, "R1 bad key A", status, 1);
      issue(8'h02, 8'h3A, 8'h42, 8'h40, 8'd3, 8'h00, 0, 1'b1, got, bs);
      chk(got && status == 3'd1, "R1 bad key B", status, 1);
      cmp_flash("R1 no flash write on key fail");
   endtask

   task automatic t_badfunc;
      bit got, bs;
      issue(8'h04, 8'h3A, 8'h13, 8'h10, 8'd1, 8'h00, 0, 1'b1, got, bs);
      chk(got && status == 3'd2, "R2 unknown code", status, 2);
      cmp_flash("R2 no flash write on unknown code");
   endtask

   task automatic t_range;
      bit got, bs;
      int r0 = rcnt;
      issue(8'h03, 8'h3A, 8'h13, 8'h10, 8'd8, 8'h00, 0, 1'b1, got, bs);
      chk(got && status == 3'd3, "R5 block out of range", status, 3);
      issue(8'h06, 8'h3A, 8'h13, 8'h10, 8'd4, 8'h00, 0, 1'b1, got, bs);
      chk(got && status == 3'd3, "R5 table out of range", status, 3);
      chk(rcnt == r0, "R5 no table strobe", rcnt - r0, 0);
      cmp_flash("R5 no flash write on range fail");
   endtask

   task automatic t_prot;
      bit got, bs;
      @(negedge clk);
      prot_we = 1'b1; prot_byte = 1'b0; prot_wdata = 8'hE4;
      @(negedge clk);
      prot_byte = 1'b1; prot_wdata = 8'h08;
      @(negedge clk);
      prot_we = 1'b0;
      issue(8'h02, 8'h3A, 8'h23, 8'h20, 8'd2, 8'h05, 1, 1'b0, got, bs);
      for (int i = 0; i < 128; i++) shadow[2*128+i] = sram[256 + ((5 + i) % 256)];
      chk(got && status == 3'd0, "R7 R6 internal copy at level 10", status, 0);
      issue(8'h03, 8'h3A, 8'h23, 8'h20, 8'd2, 8'h00, 0, 1'b1, got, bs);
      chk(got && status == 3'd4, "R7 R6 external clear at level 10", status, 4);
      issue(8'h02, 8'h3A, 8'h23, 8'h20, 8'd3, 8'h00, 0, 1'b0, got, bs);
      chk(got && status == 3'd4, "R7 R6 internal copy at level 11", status, 4);
      chk(res_key1 == 8'h01 && res_key2 == 8'h00, "R7 failure keys",
          {res_key1, res_key2}, 16'h0100);
      issue(8'h02, 8'h3A, 8'h23, 8'h20, 8'd1, 8'h80, 3, 1'b1, got, bs);
      for (int i = 0; i < 128; i++) shadow[128+i] = sram[3*256 + ((8'h80 + i) % 256)];
      chk(got && status == 3'd0, "R7 R6 external copy at level 01", status, 0);
      issue(8'h03, 8'h3A, 8'h23, 8'h20, 8'd5, 8'h00, 0, 1'b1, got, bs);
      chk(got && status == 3'd4, "R6 second byte block 5 external", status, 4);
      issue(8'h03, 8'h3A, 8'h23, 8'h20, 8'd4, 8'h00, 0, 1'b1, got, bs);
      for (int i = 0; i < 128; i++) shadow[4*128+i] = 8'h00;
      chk(got && status == 3'd0, "R6 second byte block 4 open", status, 0);
      issue(8'h03, 8'h3A, 8'h23, 8'h20, 8'd5, 8'h00, 0, 1'b0, got, bs);
      for (int i = 0; i < 128; i++) shadow[5*128+i] = 8'h00;
      chk(got && status == 3'd0, "R7 internal clear at level 10", status, 0);
      cmp_flash("R7 flash after protection tests");
   endtask

   task automatic t_table;
      bit got, bs;
      int r0 = rcnt;
      int nmis = 0;
      issue(8'h06, 8'h3A, 8'h33, 8'h30, 8'd2, 8'h00, 0, 1'b0, got, bs);
      chk(got && status == 3'd0, "R10 table status", status, 0);
      chk(rcnt - r0 == 8, "R10 table byte count", rcnt - r0, 8);
      for (int i = 0; i < 8; i++) if (rbuf[(r0 + i) % 64] !== tbl[16 + i]) nmis++;
      chk(nmis == 0, "R10 table bytes in order", rbuf[r0 % 64], tbl[16]);
      cmp_flash("R10 table read leaves flash");
   endtask

   task automatic t_clall_ext;
      bit got, bs;
      issue(8'h05, 8'h3A, 8'h03, 8'h00, 8'd0, 8'h00, 0, 1'b1, got, bs);
      for (int i = 0; i < FSZ; i++) shadow[i] = 8'h00;
      chk(got && status == 3'd0, "R8 external array clear", status, 0);
      cmp_flash("R8 array zero");
      issue(8'h02, 8'h3A, 8'h03, 8'h00, 8'd3, 8'h10, 0, 1'b1, got, bs);
      for (int i = 0; i < 128; i++) shadow[3*128+i] = sram[(8'h10 + i) % 256];
      chk(got && status == 3'd0, "R8 protection cleared", status, 0);
      cmp_flash("R8 copy after clear");
   endtask

   task automatic t_clall_int;
      bit got, bs;
      issue(8'h05, 8'h3A, 8'h03, 8'h00, 8'd0, 8'h00, 0, 1'b0, got, bs);
      chk(got && status == 3'd5, "R9 internal array clear status", status, 5);
      chk(halt == 1'b1, "R9 halt raised", halt, 1);
      cmp_flash("R9 flash untouched");
      issue(8'h03, 8'h3A, 8'h03, 8'h00, 8'd3, 8'h00, 0, 1'b1, got, bs);
      chk(!got && halt == 1'b1, "R9 commands ignored after halt", {got, halt}, 1);
      cmp_flash("R9 flash untouched after ignored command");
   endtask

   initial begin
      for (int i = 0; i < SSZ; i++) sram[i] = 8'((i * 37 + 11) % 256);
      for (int i = 0; i < FSZ; i++) begin flash[i] = 8'hA5; shadow[i] = 8'hA5; end
      for (int i = 0; i < 32; i++) tbl[i] = 8'((i * 9 + 5) % 256);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_copy();
      t_clear();
      t_badkey();
      t_badfunc();
      t_range();
      t_prot();
      t_table();
      t_clall_ext();
      t_clall_int();
      $display("test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      ntot++;
      nbad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
   end
endmodule